// File: doc/BRIEF.md
# Peer-clocked FIFO bus slave

This block is the slave side of a parallel data port. An external peer owns the timing: it drives a strobe and a direction line, and the block follows them. Two FIFOs sit between the peer and the host. The host fills the transmit FIFO and the peer reads it. The peer fills the receive FIFO and the host drains it. A read-request output tells the peer that transmit words are waiting, so it can serve as the peer's interrupt. The peer needs no flow control when it writes. A write into a full receive FIFO is discarded and raises a sticky overflow flag for the host.

The strobe and direction lines pass through a two-flop synchronizer into the system clock. A strobe rising edge is detected when the synchronized strobe goes from 0 to 1. The action for that edge is registered at the next system clock edge, so outputs change three system clocks after the strobe rises at the pin. The peer must hold the strobe high for at least three system clocks and low for at least three. It must also hold the direction line and the data it writes stable while the strobe is high.

Top module: `pbus_slave`

## Requirements
- R1: After reset, bus_oe_o, rd_req_o, tx_full_o and ovf_irq_o are 0, and rx_empty_o is 1.
- R2: rd_req_o is 1 only while the peer-clocked mode is active (mode_sel_i=1 and clk_out_i=0) and the transmit FIFO holds at least one word.
- R3: A detected strobe rise with the direction line high (1 = peer reads) pops the oldest transmit word onto bus_d_o and sets bus_oe_o to 1. Words come out in push order.
- R4: rd_req_o falls in the same system clock in which the last transmit word appears on bus_d_o. That is one system clock after the cycle in which the strobe rise is detected.
- R5: A read strobe while the transmit FIFO is empty pops nothing, sets bus_oe_o to 0 and leaves bus_d_o unchanged.
- R6: A detected strobe rise with the direction line low (0 = peer writes) pushes bus_d_i into the receive FIFO and sets bus_oe_o to 0. The host reads words at rx_data_o, oldest first, and removes each with rx_pop_i.
- R7: A peer write while the receive FIFO is full is dropped. The stored words are left unchanged, and the overflow flag is set.
- R8: The overflow flag stays set until a one-cycle pulse on ovf_clr_i clears it. An overflow in the same cycle as a clear leaves the flag set. ovf_irq_o is the flag ANDed with ovf_ie_i.
- R9: Outside the peer-clocked mode, strobes are ignored and bus_oe_o goes to 0 one clock after the mode is left.
- R10: tx_full_o is 1 when 16 words are held. A host push while the transmit FIFO is full is dropped.
- R11: A host push and a peer read of the transmit FIFO in the same cycle both take effect. The FIFO order and the request state stay correct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_sel_i | input | 1 | Mode select; must be 1 for peer-clocked operation |
| clk_out_i | input | 1 | Clock-output select; must be 0 for peer-clocked operation |
| stb_i | input | 1 | Strobe from the peer (asynchronous) |
| dir_i | input | 1 | Direction from the peer, 1 = read, 0 = write |
| bus_d_i | input | 16 | Data bus input from the peer |
| bus_d_o | output | 16 | Data bus output to the peer |
| bus_oe_o | output | 1 | Data bus output enable |
| rd_req_o | output | 1 | Read request to the peer |
| tx_push_i | input | 1 | Host push into the transmit FIFO |
| tx_data_i | input | 16 | Host transmit word |
| tx_full_o | output | 1 | Transmit FIFO full |
| rx_pop_i | input | 1 | Host pop from the receive FIFO |
| rx_data_o | output | 16 | Head of the receive FIFO |
| rx_empty_o | output | 1 | Receive FIFO empty |
| ovf_clr_i | input | 1 | Clear pulse for the overflow flag |
| ovf_ie_i | input | 1 | Overflow interrupt enable |
| ovf_irq_o | output | 1 | Overflow interrupt |

## Verification
Two pairs of functions can land on the same clock edge. The first pair is a host push and a peer pop of the transmit FIFO. The bench raises tx_push_i in the cycle in which the strobe rise is detected. It then checks that the popped word is the older one, that rd_req_o stays high, and that the next read returns the pushed word. The second pair is a receive overflow and a host clear. The bench pulses ovf_clr_i in the detection cycle of a write into a full receive FIFO and expects the flag to stay set.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
  localparam int unsigned DATA_W     = 16;
  localparam int unsigned FIFO_DEPTH = 16;
  localparam int unsigned SYNC_STG   = 2;

  typedef enum logic [1:0] {
    CYC_NONE = 2'd0,
    CYC_RD   = 2'd1,
    CYC_WR   = 2'd2
  } cyc_e;
endpackage

// File: rtl/pbus_strobe_sync.sv
module pbus_strobe_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stb_i,
  input  logic dir_i,
  output logic rise_o,
  output logic dir_o
);
  // bit 0 strobe, bit 1 direction
  logic [1:0] chain [STAGES];
  logic       stb_prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
      stb_prev <= 1'b0;
    end else begin
      chain[0] <= {dir_i, stb_i};
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      stb_prev <= chain[STAGES-1][0];
    end
  end

  assign rise_o = chain[STAGES-1][0] & ~stb_prev;
  assign dir_o  = chain[STAGES-1][1];
endmodule

// File: rtl/pbus_fifo.sv
module pbus_fifo #(
  parameter int unsigned W     = 16,
  parameter int unsigned DEPTH = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;
  logic          pop_ok, push_ok;

  assign full_o  = (cnt == CW'(DEPTH));
  assign empty_o = (cnt == '0);
  assign pop_ok  = pop_i & ~empty_o;
  assign push_ok = push_i & (~full_o | pop_ok);
  assign data_o  = mem[rd_ptr];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_ok) mem[wr_ptr] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push_ok) wr_ptr <= nxt(wr_ptr);
      if (pop_ok)  rd_ptr <= nxt(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/pbus_slave.sv
module pbus_slave
  import pbus_pkg::*;
#(
  parameter int unsigned DW    = DATA_W,
  parameter int unsigned DEPTH = FIFO_DEPTH
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mode_sel_i,
  input  logic          clk_out_i,
  input  logic          stb_i,
  input  logic          dir_i,
  input  logic [DW-1:0] bus_d_i,
  output logic [DW-1:0] bus_d_o,
  output logic          bus_oe_o,
  output logic          rd_req_o,
  input  logic          tx_push_i,
  input  logic [DW-1:0] tx_data_i,
  output logic          tx_full_o,
  input  logic          rx_pop_i,
  output logic [DW-1:0] rx_data_o,
  output logic          rx_empty_o,
  input  logic          ovf_clr_i,
  input  logic          ovf_ie_i,
  output logic          ovf_irq_o
);
  logic          active, strobe_rise, dir_smp;
  logic          tx_empty, tx_pop, rx_full, rx_push, ovf_set, ovf_q, oe_q;
  logic [DW-1:0] tx_head, bus_q;
  cyc_e          cyc;

  assign active = mode_sel_i & ~clk_out_i;

  pbus_strobe_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .stb_i  (stb_i),
    .dir_i  (dir_i),
    .rise_o (strobe_rise),
    .dir_o  (dir_smp)
  );

  always_comb begin
    cyc = CYC_NONE;
    if (active && strobe_rise) cyc = dir_smp ? CYC_RD : CYC_WR;
  end

  assign tx_pop  = (cyc == CYC_RD) & ~tx_empty;
  assign rx_push = (cyc == CYC_WR) & ~rx_full;
  assign ovf_set = (cyc == CYC_WR) & rx_full;

  pbus_fifo #(.W(DW), .DEPTH(DEPTH)) u_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (tx_push_i),
    .data_i  (tx_data_i),
    .pop_i   (tx_pop),
    .data_o  (tx_head),
    .full_o  (tx_full_o),
    .empty_o (tx_empty)
  );

  pbus_fifo #(.W(DW), .DEPTH(DEPTH)) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (rx_push),
    .data_i  (bus_d_i),
    .pop_i   (rx_pop_i),
    .data_o  (rx_data_o),
    .full_o  (rx_full),
    .empty_o (rx_empty_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_q  <= 1'b0;
      bus_q <= '0;
    end else if (!active) begin
      oe_q <= 1'b0;
    end else begin
      case (cyc)
        CYC_RD: begin
          oe_q <= ~tx_empty;
          if (!tx_empty) bus_q <= tx_head;
        end
        CYC_WR:  oe_q <= 1'b0;
        default: oe_q <= oe_q;
      endcase
    end
  end

  // set dominates a concurrent clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ovf_q <= 1'b0;
    else if (ovf_set)   ovf_q <= 1'b1;
    else if (ovf_clr_i) ovf_q <= 1'b0;
  end

  assign bus_d_o   = bus_q;
  assign bus_oe_o  = oe_q;
  assign rd_req_o  = active & ~tx_empty;
  assign ovf_irq_o = ovf_q & ovf_ie_i;
endmodule

// File: rtl/pbus_slave_chk.sv
module pbus_slave_chk #(
  parameter int unsigned DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          active,
  input logic          strobe_rise,
  input logic          dir_smp,
  input logic          rd_req_o,
  input logic          bus_oe_o,
  input logic [DW-1:0] bus_d_o,
  input logic          tx_pop,
  input logic          rx_full,
  input logic          rx_push,
  input logic          ovf_irq_o,
  input logic          ovf_ie_i,
  input logic          ovf_clr_i
);
  a_r3_drive_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_oe_o) |-> $past(rd_req_o));

  a_r4_req_drop_on_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && $past(active) && $fell(rd_req_o)) |-> $past(tx_pop));

  a_r5_empty_read_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && strobe_rise && dir_smp && !rd_req_o) |=> (!bus_oe_o && $stable(bus_d_o)));

  a_r7_no_push_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_full |-> !rx_push);

  a_r8_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_ie_i && $past(ovf_ie_i) && $past(ovf_irq_o) && !$past(ovf_clr_i)) |-> ovf_irq_o);

  a_r9_oe_off_inactive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |=> !bus_oe_o);
endmodule

bind pbus_slave pbus_slave_chk #(.DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .active      (active),
  .strobe_rise (strobe_rise),
  .dir_smp     (dir_smp),
  .rd_req_o    (rd_req_o),
  .bus_oe_o    (bus_oe_o),
  .bus_d_o     (bus_d_o),
  .tx_pop      (tx_pop),
  .rx_full     (rx_full),
  .rx_push     (rx_push),
  .ovf_irq_o   (ovf_irq_o),
  .ovf_ie_i    (ovf_ie_i),
  .ovf_clr_i   (ovf_clr_i)
);

// File: tb/sim_pbus_slave.sv
`timescale 1ns/1ps
module sim_pbus_slave;
  localparam int CLK_T = 10;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        mode_sel_i = 1'b1, clk_out_i = 1'b0, stb_i = 1'b0, dir_i = 1'b0;
  logic [15:0] bus_d_i = '0, tx_data_i = '0;
  logic        tx_push_i = 1'b0, rx_pop_i = 1'b0, ovf_clr_i = 1'b0, ovf_ie_i = 1'b1;
  logic [15:0] bus_d_o, rx_data_o;
  logic        bus_oe_o, rd_req_o, tx_full_o, rx_empty_o, ovf_irq_o;

  int n_chk = 0, n_err = 0;
  logic pre_req;

  always #(CLK_T/2) clk_i = ~clk_i;

  pbus_slave u0 (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic host_push(input logic [15:0] d);
    @(negedge clk_i); tx_push_i = 1'b1; tx_data_i = d;
    @(negedge clk_i); tx_push_i = 1'b0;
  endtask

  task automatic host_pop(input string tag, input logic [15:0] exp);
    @(negedge clk_i);
    chk(tag, rx_data_o, exp);
    rx_pop_i = 1'b1;
    @(negedge clk_i); rx_pop_i = 1'b0;
  endtask

  // strobe high three clocks, low three; optional host action in detection cycle
  task automatic strobe(input logic dir, input logic [15:0] d,
                        input bit push_at, input logic [15:0] pw, input bit clr_at);
    @(negedge clk_i); dir_i = dir; bus_d_i = d; stb_i = 1'b1;
    @(negedge clk_i);
    @(negedge clk_i);
    if (push_at) begin tx_push_i = 1'b1; tx_data_i = pw; end
    if (clr_at) ovf_clr_i = 1'b1;
    pre_req = rd_req_o;
    @(negedge clk_i);
    tx_push_i = 1'b0; ovf_clr_i = 1'b0; stb_i = 1'b0;
    repeat (3) @(negedge clk_i);
  endtask

  // {dir, bus_in, exp_oe, exp_bus, exp_req}
  localparam logic [34:0] VEC [5] = '{
    {1'b1, 16'h0000, 1'b1, 16'h1111, 1'b1},
    {1'b0, 16'hA0A0, 1'b0, 16'h1111, 1'b1},
    {1'b1, 16'h0000, 1'b1, 16'h2222, 1'b0},
    {1'b1, 16'h0000, 1'b0, 16'h2222, 1'b0},
    {1'b0, 16'h0B0B, 1'b0, 16'h2222, 1'b0}
  };

  initial begin
    #(CLK_T * 150000);
    n_err++; n_chk++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 oe", bus_oe_o, 0);
    chk("R1 req", rd_req_o, 0);
    chk("R1 full", tx_full_o, 0);
    chk("R1 empty", rx_empty_o, 1);
    chk("R1 irq", ovf_irq_o, 0);
    rst_ni = 1'b1;

    host_push(16'h1111);
    host_push(16'h2222);
    @(negedge clk_i);
    chk("R2 req with data", rd_req_o, 1);
    foreach (VEC[i]) begin
      strobe(VEC[i][34], VEC[i][33:18], 0, '0, 0);
      chk($sformatf("R3/R5/R6 vec%0d oe", i), bus_oe_o, VEC[i][17]);
      chk($sformatf("R3/R5 vec%0d bus", i), bus_d_o, VEC[i][16:1]);
      chk($sformatf("R2/R4 vec%0d req", i), rd_req_o, VEC[i][0]);
    end
    host_pop("R6 first write", 16'hA0A0);
    host_pop("R6 second write", 16'h0B0B);
    chk("R6 rx drained", rx_empty_o, 1);

    // R11 simultaneous push and pop, then R4 timing on last word
    host_push(16'h7777);
    strobe(1'b1, '0, 1, 16'h8888, 0);
    chk("R11 popped older", bus_d_o, 16'h7777);
    chk("R11 req kept", rd_req_o, 1);
    strobe(1'b1, '0, 0, '0, 0);
    chk("R11 pushed word", bus_d_o, 16'h8888);
    chk("R4 req before last pop", pre_req, 1);
    chk("R4 req after last pop", rd_req_o, 0);

    // R10 full transmit FIFO
    for (int i = 0; i < 17; i++) host_push(16'h3000 + 16'(i));
    chk("R10 tx full", tx_full_o, 1);
    for (int i = 0; i < 16; i++) begin
      strobe(1'b1, '0, 0, '0, 0);
      chk("R10 order", bus_d_o, 16'h3000 + 16'(i));
    end
    chk("R10 extra dropped req", rd_req_o, 0);
    chk("R10 not full", tx_full_o, 0);

    // R9 mode gating
    mode_sel_i = 1'b0;
    host_push(16'h5555);
    chk("R9 req gated", rd_req_o, 0);
    strobe(1'b1, '0, 0, '0, 0);
    chk("R9 strobe ignored oe", bus_oe_o, 0);
    mode_sel_i = 1'b1;
    @(negedge clk_i);
    chk("R9 req back", rd_req_o, 1);
    strobe(1'b1, '0, 0, '0, 0);
    chk("R9 word kept", bus_d_o, 16'h5555);
    chk("R9 oe on", bus_oe_o, 1);
    clk_out_i = 1'b1;
    @(negedge clk_i);
    chk("R9 oe released", bus_oe_o, 0);
    clk_out_i = 1'b0;

    // R7 / R8 overflow, set vs clear in same cycle
    for (int i = 0; i < 16; i++) strobe(1'b0, 16'hC000 + 16'(i), 0, '0, 0);
    chk("R7 no irq yet", ovf_irq_o, 0);
    strobe(1'b0, 16'hDEAD, 0, '0, 1);
    chk("R8 set wins over clear", ovf_irq_o, 1);
    ovf_ie_i = 1'b0;
    @(negedge clk_i);
    chk("R8 irq masked", ovf_irq_o, 0);
    ovf_ie_i = 1'b1;
    @(negedge clk_i);
    chk("R8 sticky", ovf_irq_o, 1);
    ovf_clr_i = 1'b1;
    @(negedge clk_i); ovf_clr_i = 1'b0;
    chk("R8 cleared", ovf_irq_o, 0);
    for (int i = 0; i < 16; i++) host_pop("R7 contents kept", 16'hC000 + 16'(i));
    chk("R7 dropped word absent", rx_empty_o, 1);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule